// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block issues one command at a time to a memory card and gathers the card's reply into a bank of 32-bit response words. Software writes a 32-bit argument register and a command register. The command register holds a 6-bit command index and a few control bits. A write that sets the enable bit starts a command. The block then pulses a request to the card side, carrying the index and the argument. It waits for the card to return a byte-serial reply, which ends with an end marker that carries the total byte count.

When the end marker arrives, the block classifies the outcome. It sets exactly one of three sticky completion flags: command sent, response received or timeout. A valid reply is copied into the response words most-significant byte first. A neighbouring status block clears the flags through a per-flag clear input. A busy output covers the time from the issue of a command until its completion.

Top module: `card_cmd_sequencer`

## Requirements
- R1: After reset the three flags, `busy`, `req_valid`, every response word and the command readback are all zero.
- R2: The command register decodes these fields: bits 5:0 are the index, bit 6 means a response is expected, bit 7 means a long response, bit 9 means pending and bit 10 is enable. A write while idle, with bit 10 set and bit 9 clear, raises `req_valid` for exactly one cycle, in the cycle after the write. That cycle carries `req_index` equal to bits 5:0 and `req_arg` equal to the argument register. `busy` rises in the same cycle and stays high until completion.
- R3: A command write with the pending bit (9) set, or with the enable bit (10) clear, produces no request and leaves `busy` low. The readback equals the written value with bit 10 forced to zero.
- R4: Bit 10 of the command readback is one while a command is in flight and reads zero after completion, whatever the outcome.
- R5: If bit 6 of the command is clear, completion sets `flag_sent`.
- R6: If bit 6 is set, completion sets `flag_tmo` in three cases: a byte count of 0, a count of 4 on a command with bit 7 set, or any count other than 4 or 16. In all three cases the response words keep their previous values.
- R7: If bit 6 is set and the reply is valid, completion sets `flag_resp`. Reply bytes are packed big-endian: the first byte received lands in bits 31:24 of word 0 (`resp_words[31:0]`).
- R8: A valid 4-byte reply writes word 0 and sets words 1 to 3 to zero.
- R9: A 16-byte reply writes all four words in arrival order. Bit 0 of word 3 (`resp_words[96]`) is always forced to zero.
- R10: The flags are sticky. Bits 0, 1 and 2 of `flag_clr` clear `flag_sent`, `flag_resp` and `flag_tmo`. If a clear and a set of the same flag fall in the same cycle, the set wins.
- R11: Command writes that arrive while `busy` is high are ignored. They neither change the command readback nor start a request.
- R12: A reply byte that arrives in the same cycle as the end marker is part of the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write value |
| cmd_rdata | output | 32 | Command register readback |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write value |
| req_valid | output | 1 | One-cycle request to the card |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_byte_valid | input | 1 | Reply byte strobe from the card |
| rsp_byte | input | 8 | Reply byte |
| rsp_end | input | 1 | End of reply marker |
| rsp_count | input | CNT_W | Total reply byte count, valid with `rsp_end` |
| flag_clr | input | 3 | Per-flag clear: bit 0 sent, bit 1 response, bit 2 timeout |
| flag_sent | output | 1 | Sticky command-sent flag |
| flag_resp | output | 1 | Sticky response-received flag |
| flag_tmo | output | 1 | Sticky timeout flag |
| busy | output | 1 | Command in flight |
| resp_words | output | 32*LONG_WORDS | Response words, word w at bits 32w+31:32w |

## Verification
Two collisions are provoked on purpose.

In the first, the card model drives the last reply byte together with the end marker. The bench then checks that this byte lands in the low byte of the last word, and that the valid-reply flag rises in the same cycle. Both checks are judged against words the bench assembled itself.

In the second, a completion lands while the status side is clearing that very flag. The bench expects the flag to stay set afterwards. A clear applied on its own, in a later cycle, must drop the flag.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
   // command register field positions (decoded by the sequencer)
   localparam int unsigned CMD_IDX_W    = 6;
   localparam int unsigned CMD_RSP_BIT  = 6;
   localparam int unsigned CMD_LONG_BIT = 7;
   localparam int unsigned CMD_PEND_BIT = 9;
   localparam int unsigned CMD_EN_BIT   = 10;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned SHORT_BYTES  = 4;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      OUT_SENT  = 2'd0,
      OUT_SHORT = 2'd1,
      OUT_LONG  = 2'd2,
      OUT_TMO   = 2'd3
   } outcome_e;
endpackage

// File: rtl/cmdseq_cmd_reg.sv
module cmdseq_cmd_reg
   import cmdseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              busy,
   input  logic              done,
   output logic [WORD_W-1:0] cmd_q,
   output logic              issue
);
   logic              start_ok;
   logic              accept;
   logic [WORD_W-1:0] cmd_nx;

   assign start_ok = wdata[CMD_EN_BIT] && !wdata[CMD_PEND_BIT];
   assign accept   = wr && !busy;
   assign issue    = accept && start_ok;

   always_comb begin
      cmd_nx = cmd_q;
      if (accept) begin
         cmd_nx             = wdata;
         cmd_nx[CMD_EN_BIT] = start_ok;
      end else if (done) begin
         cmd_nx[CMD_EN_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= cmd_nx;
   end

   // R3
   pend_noissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy && wdata[CMD_PEND_BIT]) |=> !cmd_q[CMD_EN_BIT]);
endmodule

// File: rtl/cmdseq_rsp_capture.sv
module cmdseq_rsp_capture
   import cmdseq_pkg::*;
#(
   parameter int unsigned TOT_BYTES = 16,
   localparam int unsigned TOT_BITS = TOT_BYTES * 8,
   localparam int unsigned IDX_W    = $clog2(TOT_BYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                take,
   input  logic [7:0]          byte_in,
   output logic [TOT_BITS-1:0] buf_nx
);
   logic [TOT_BITS-1:0] buf_q;
   logic [IDX_W-1:0]    idx_q;
   logic [IDX_W-1:0]    idx_nx;

   always_comb begin
      buf_nx = buf_q;
      idx_nx = idx_q;
      if (start) begin
         buf_nx = '0;
         idx_nx = '0;
      end else if (take && (idx_q < IDX_W'(TOT_BYTES))) begin
         for (int k = 0; k < int'(TOT_BYTES); k++) begin
            if (idx_q == IDX_W'(k)) buf_nx[TOT_BITS-1-8*k -: 8] = byte_in;
         end
         idx_nx = idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         idx_q <= '0;
      end else begin
         buf_q <= buf_nx;
         idx_q <= idx_nx;
      end
   end

   // R12
   cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(TOT_BYTES));
endmodule

// File: rtl/cmdseq_rsp_judge.sv
module cmdseq_rsp_judge
   import cmdseq_pkg::*;
#(
   parameter int unsigned LONG_BYTES = 16,
   parameter int unsigned CNT_W      = 5
) (
   input  logic             expect_rsp,
   input  logic             long_rsp,
   input  logic [CNT_W-1:0] count,
   output outcome_e         outcome
);
   always_comb begin
      if (!expect_rsp)                                        outcome = OUT_SENT;
      else if ((count == CNT_W'(SHORT_BYTES)) && !long_rsp)   outcome = OUT_SHORT;
      else if (count == CNT_W'(LONG_BYTES))                   outcome = OUT_LONG;
      else                                                    outcome = OUT_TMO;
   end
endmodule

// File: rtl/card_cmd_sequencer.sv
module card_cmd_sequencer
   import cmdseq_pkg::*;
#(
   parameter int unsigned LONG_WORDS = 4,
   parameter int unsigned CNT_W      = 5,
   localparam int unsigned LONG_BYTES = LONG_WORDS * 4,
   localparam int unsigned RESP_BITS  = LONG_WORDS * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic [31:0]          cmd_wdata,
   output logic [31:0]          cmd_rdata,
   input  logic                 arg_wr,
   input  logic [31:0]          arg_wdata,
   output logic                 req_valid,
   output logic [5:0]           req_index,
   output logic [31:0]          req_arg,
   input  logic                 rsp_byte_valid,
   input  logic [7:0]           rsp_byte,
   input  logic                 rsp_end,
   input  logic [CNT_W-1:0]     rsp_count,
   input  logic [2:0]           flag_clr,
   output logic                 flag_sent,
   output logic                 flag_resp,
   output logic                 flag_tmo,
   output logic                 busy,
   output logic [RESP_BITS-1:0] resp_words
);
   if (LONG_WORDS < 2) begin : g_bad_words
      $error("LONG_WORDS must be at least 2");
   end
   if ((2 ** CNT_W) <= LONG_BYTES) begin : g_bad_cnt
      $error("CNT_W too narrow for the long reply length");
   end

   seq_state_e          state_q;
   seq_state_e          state_nx;
   logic [WORD_W-1:0]   cmd_q;
   logic [WORD_W-1:0]   arg_q;
   logic                issue;
   logic                done;
   outcome_e            outcome;
   logic [RESP_BITS-1:0] cap_buf;
   logic                set_sent, set_resp, set_tmo;

   assign done = (state_q == SEQ_WAIT) && rsp_end;
   assign busy = (state_q != SEQ_IDLE);

   cmdseq_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmd_wr),
      .wdata (cmd_wdata),
      .busy  (busy),
      .done  (done),
      .cmd_q (cmd_q),
      .issue (issue)
   );

   cmdseq_rsp_capture #(.TOT_BYTES(LONG_BYTES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (issue),
      .take    (rsp_byte_valid && (state_q == SEQ_WAIT)),
      .byte_in (rsp_byte),
      .buf_nx  (cap_buf)
   );

   cmdseq_rsp_judge #(.LONG_BYTES(LONG_BYTES), .CNT_W(CNT_W)) u_judge (
      .expect_rsp (cmd_q[CMD_RSP_BIT]),
      .long_rsp   (cmd_q[CMD_LONG_BIT]),
      .count      (rsp_count),
      .outcome    (outcome)
   );

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         SEQ_IDLE:  if (issue) state_nx = SEQ_ISSUE;
         SEQ_ISSUE: state_nx = SEQ_WAIT;
         SEQ_WAIT:  if (rsp_end) state_nx = SEQ_IDLE;
         default:   state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         arg_q   <= '0;
      end else begin
         state_q <= state_nx;
         if (arg_wr) arg_q <= arg_wdata;
      end
   end

   assign req_valid = (state_q == SEQ_ISSUE);
   assign req_index = cmd_q[CMD_IDX_W-1:0];
   assign req_arg   = arg_q;
   assign cmd_rdata = cmd_q;

   assign set_sent = done && (outcome == OUT_SENT);
   assign set_resp = done && ((outcome == OUT_SHORT) || (outcome == OUT_LONG));
   assign set_tmo  = done && (outcome == OUT_TMO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_sent <= 1'b0;
         flag_resp <= 1'b0;
         flag_tmo  <= 1'b0;
      end else begin
         flag_sent <= (flag_sent && !flag_clr[0]) || set_sent;
         flag_resp <= (flag_resp && !flag_clr[1]) || set_resp;
         flag_tmo  <= (flag_tmo  && !flag_clr[2]) || set_tmo;
      end
   end

   for (genvar w = 0; w < int'(LONG_WORDS); w++) begin : g_word
      logic [WORD_W-1:0] cap_word;
      logic [WORD_W-1:0] long_val;
      logic [WORD_W-1:0] short_val;
      assign cap_word  = cap_buf[RESP_BITS-1-WORD_W*w -: WORD_W];
      if (w == int'(LONG_WORDS) - 1) begin : g_last
         assign long_val = {cap_word[WORD_W-1:1], 1'b0};
      end else begin : g_mid
         assign long_val = cap_word;
      end
      if (w == 0) begin : g_first
         assign short_val = cap_word;
      end else begin : g_rest
         assign short_val = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              resp_words[WORD_W*w +: WORD_W] <= '0;
         else if (done && outcome == OUT_SHORT)   resp_words[WORD_W*w +: WORD_W] <= short_val;
         else if (done && outcome == OUT_LONG)    resp_words[WORD_W*w +: WORD_W] <= long_val;
      end
   end

   // R2
   issue_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> req_valid);
   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   // R4
   en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_rdata[CMD_EN_BIT]);
   // R5
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (flag_sent || flag_resp || flag_tmo));
   // R9
   end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_words[WORD_W*(LONG_WORDS-1)]);
   // R10
   tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_tmo && !flag_clr[2]) |=> flag_tmo);
   // R11
   busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SEQ_ISSUE) && cmd_wr) |=> $stable(cmd_rdata));
endmodule

// File: tb/test_card_cmd_sequencer.sv
module test_card_cmd_sequencer;
   localparam int LW = 4;
   localparam int CW = 5;
   localparam logic [31:0] EN = 32'h400, PEND = 32'h200, LNG = 32'h80, RSP = 32'h40;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          cmd_wr = 0, arg_wr = 0;
   logic [31:0]   cmd_wdata = 0, arg_wdata = 0;
   logic [31:0]   cmd_rdata;
   logic          req_valid;
   logic [5:0]    req_index;
   logic [31:0]   req_arg;
   logic          rsp_byte_valid = 0, rsp_end = 0;
   logic [7:0]    rsp_byte = 0;
   logic [CW-1:0] rsp_count = 0;
   logic [2:0]    flag_clr = 0;
   logic          flag_sent, flag_resp, flag_tmo, busy;
   logic [LW*32-1:0] resp_words;

   int n_chk = 0, n_bad = 0;
   logic [31:0] exp_w [4] = '{default: 32'h0};

   card_cmd_sequencer #(.LONG_WORDS(LW), .CNT_W(CW)) i_card_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .arg_wr(arg_wr), .arg_wdata(arg_wdata), .req_valid(req_valid), .req_index(req_index),
      .req_arg(req_arg), .rsp_byte_valid(rsp_byte_valid), .rsp_byte(rsp_byte), .rsp_end(rsp_end),
      .rsp_count(rsp_count), .flag_clr(flag_clr), .flag_sent(flag_sent), .flag_resp(flag_resp),
      .flag_tmo(flag_tmo), .busy(busy), .resp_words(resp_words));

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_flags(input string tag, input logic s, input logic r, input logic t);
      chk(tag, {29'b0, flag_sent, flag_resp, flag_tmo}, {29'b0, s, r, t});
   endtask

   task automatic chk_words(input string tag);
      for (int w = 0; w < 4; w++) chk(tag, resp_words[32*w +: 32], exp_w[w]);
   endtask

   // issue a command, feed the reply, leave the bench one cycle after completion
   task automatic run_cmd(input logic [31:0] cw, input logic [31:0] arg, input logic [127:0] bytes,
                          input int nb, input int cnt, input bit merge, input bit pre_clr,
                          input logic [2:0] clr_end);
      @(negedge clk);
      flag_clr = pre_clr ? 3'b111 : 3'b000; arg_wr = 1; arg_wdata = arg;
      @(negedge clk);
      flag_clr = 0; arg_wr = 0; cmd_wr = 1; cmd_wdata = cw;
      @(negedge clk);
      cmd_wr = 0;
      chk("R2 req_valid", {31'b0, req_valid}, 32'd1);
      chk("R2 req_index", {26'b0, req_index}, {26'b0, cw[5:0]});
      chk("R2 req_arg", req_arg, arg);
      chk("R2 busy", {31'b0, busy}, 32'd1);
      chk("R4 enable while busy", {31'b0, cmd_rdata[10]}, 32'd1);
      @(negedge clk);
      chk("R2 single pulse", {31'b0, req_valid}, 32'd0);
      for (int k = 0; k < nb; k++) begin
         rsp_byte_valid = 1; rsp_byte = bytes[127-8*k -: 8];
         if (merge && k == nb - 1) begin
            rsp_end = 1; rsp_count = CW'(cnt); flag_clr = clr_end;
         end
         @(negedge clk);
      end
      if (!merge || nb == 0) begin
         rsp_byte_valid = 0; rsp_end = 1; rsp_count = CW'(cnt); flag_clr = clr_end;
         @(negedge clk);
      end
      rsp_byte_valid = 0; rsp_end = 0; flag_clr = 0;
      chk("R2 busy low after end", {31'b0, busy}, 32'd0);
      chk("R4 enable cleared", {31'b0, cmd_rdata[10]}, 32'd0);
   endtask

   task automatic t_reset();
      chk_flags("R1 flags", 0, 0, 0);
      chk("R1 busy", {31'b0, busy}, 0);
      chk("R1 req_valid", {31'b0, req_valid}, 0);
      chk("R1 cmd readback", cmd_rdata, 0);
      chk_words("R1 words");
   endtask

   task automatic t_no_resp();
      run_cmd(EN | 32'd5, 32'hDEAD_0001, '0, 0, 0, 0, 1, 3'b000);
      chk_flags("R5 sent", 1, 0, 0);
      chk_words("R5 words untouched");
   endtask

   task automatic t_long();
      logic [127:0] b;
      for (int k = 0; k < 16; k++) b[127-8*k -: 8] = 8'hA0 + 8'(k);
      run_cmd(EN | RSP | LNG | 32'd2, 32'h1234_5678, b, 16, 16, 1, 1, 3'b000);
      exp_w[0] = 32'hA0A1A2A3; exp_w[1] = 32'hA4A5A6A7;
      exp_w[2] = 32'hA8A9AAAB; exp_w[3] = 32'hACADAEAE;
      chk_flags("R7 R12 resp", 0, 1, 0);
      chk_words("R9 R12 long words");
   endtask

   task automatic t_short();
      run_cmd(EN | RSP | 32'd17, 32'h0, {32'h11223344, 96'h0}, 4, 4, 0, 1, 3'b000);
      exp_w[0] = 32'h11223344; exp_w[1] = 0; exp_w[2] = 0; exp_w[3] = 0;
      chk_flags("R7 resp", 0, 1, 0);
      chk_words("R8 short words");
   endtask

   task automatic t_timeouts();
      run_cmd(EN | RSP | 32'd1, 32'h0, '0, 0, 0, 0, 1, 3'b000);
      chk_flags("R6 zero bytes", 0, 0, 1);
      chk_words("R6 words kept zero-len");
      run_cmd(EN | RSP | LNG | 32'd9, 32'h0, {32'h55667788, 96'h0}, 4, 4, 0, 1, 3'b000);
      chk_flags("R6 short on long", 0, 0, 1);
      chk_words("R6 words kept short-on-long");
      run_cmd(EN | RSP | 32'd3, 32'h0, {64'hF0F1F2F3F4F5F6F7, 64'h0}, 8, 8, 0, 1, 3'b000);
      chk_flags("R6 odd length", 0, 0, 1);
      chk_words("R6 words kept odd length");
   endtask

   task automatic t_pending();
      @(negedge clk); cmd_wr = 1; cmd_wdata = EN | PEND | 32'd9;
      @(negedge clk); cmd_wr = 0;
      chk("R3 pending no request", {31'b0, req_valid}, 0);
      chk("R3 pending not busy", {31'b0, busy}, 0);
      chk("R3 pending readback", cmd_rdata, PEND | 32'd9);
      @(negedge clk); cmd_wr = 1; cmd_wdata = RSP | 32'd3;
      @(negedge clk); cmd_wr = 0;
      chk("R3 disabled no request", {31'b0, req_valid}, 0);
      chk("R3 disabled readback", cmd_rdata, RSP | 32'd3);
   endtask

   task automatic t_sticky();
      run_cmd(EN | 32'd4, 32'h0, '0, 0, 0, 0, 1, 3'b000);
      repeat (3) @(negedge clk);
      chk_flags("R10 sticky", 1, 0, 0);
      // completion and clear of the same flag in one cycle: set wins
      run_cmd(EN | 32'd6, 32'h0, '0, 0, 0, 0, 0, 3'b001);
      chk_flags("R10 set beats clear", 1, 0, 0);
      flag_clr = 3'b001;
      @(negedge clk); flag_clr = 0;
      chk_flags("R10 clear alone", 0, 0, 0);
   endtask

   task automatic t_busy_wr();
      @(negedge clk); flag_clr = 3'b111;
      @(negedge clk); flag_clr = 0; cmd_wr = 1; cmd_wdata = EN | RSP | 32'd7;
      @(negedge clk); cmd_wr = 1; cmd_wdata = EN | 32'd33;
      @(negedge clk); cmd_wr = 0;
      chk("R11 readback while busy", cmd_rdata, EN | RSP | 32'd7);
      rsp_end = 1; rsp_count = 0;
      @(negedge clk); rsp_end = 0;
      chk("R11 readback after", cmd_rdata, RSP | 32'd7);
      chk_flags("R11 outcome of first command", 0, 0, 1);
      @(negedge clk);
      chk("R11 no second request", {31'b0, req_valid}, 0);
      chk("R11 idle", {31'b0, busy}, 0);
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_no_resp();
      t_long();
      t_short();
      t_timeouts();
      t_pending();
      t_sticky();
      t_busy_wr();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule